// File: doc/BRIEF.md
# Fetch Show Cycle Filter

The filter sits between a processor core's instruction-fetch reporting path and the external-bus show-cycle logic. For each fetch the core reports, it decides whether an external show cycle is requested. The decision depends on a 3-bit show-control mode, the level of a trace synchronisation input (vsync), and the kind of fetch: a sequential fetch, a direct change of flow, or an indirect change of flow. Fetches that pass the filter are queued as show requests. Each request carries the fetch address and an attribute flag that marks program-trace cycles.

Every change of the vsync level, whether a rise or a fall, injects one attribute-marked trace request. That request takes precedence over a fetch arriving in the same clock, and the fetch is taken in a later cycle. A small FIFO absorbs downstream stalls. When the FIFO is full, fetch acceptance is held off. A fetch that is stalled keeps the mode and vsync level it saw when it was first presented. The address output is driven only while a request is presented, so downstream logic can sample it on the strobe alone.

Top module: `fsc_show_filter`

## Requirements
- R1: With ctrl_mode[1:0] = 00, every accepted fetch produces one show request, whatever the vsync level and ctrl_mode[2]. fetch_kind encodes 00 sequential, 01 direct change of flow, 10 indirect change of flow, and 11 reserved, which is treated as sequential.
- R2: With ctrl_mode[1:0] = 01, only fetches of kind 01 or 10 produce a show request.
- R3: With ctrl_mode[1:0] = 10, only fetches of kind 10 produce a show request.
- R4: With ctrl_mode[1:0] = 11, no fetch produces a show request while vsync is 0. While vsync is 1, only kind 10 produces one.
- R5: Each change of the vsync level produces exactly one show request with show_trace = 1. Its address is that of the most recently accepted fetch, or zero if no fetch has been accepted since reset. Requests made for fetches have show_trace = 0.
- R6: show_addr is zero in every cycle in which show_valid is low.
- R7: Show requests leave in the order they were made, through a FIFO of DEPTH entries (4 by default). fetch_ready is low whenever the FIFO holds DEPTH entries. The FIFO neither overflows nor underflows.
- R8: In a cycle where vsync differs from its value in the previous clock, or while an earlier trace request still waits for FIFO space, fetch_ready is low. A fetch presented then is accepted in a later cycle.
- R9: A fetch held by fetch_ready = 0 is filtered with the ctrl_mode and vsync values present in its first presented cycle. Changes during the stall do not affect it.
- R10: While rst_n is low, fetch_ready and show_valid are low. After reset, with vsync unchanged, fetch_ready is high and show_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_mode | input | 3 | Show-control mode; the low two bits select the filter |
| vsync | input | 1 | Trace synchronisation level |
| fetch_valid | input | 1 | Fetch report valid |
| fetch_ready | output | 1 | Fetch report accepted when high together with fetch_valid |
| fetch_kind | input | 2 | Fetch kind: 00 sequential, 01 direct, 10 indirect, 11 reserved |
| fetch_addr | input | AW | Fetch address |
| show_valid | output | 1 | Show request strobe |
| show_ready | input | 1 | Downstream takes the request |
| show_addr | output | AW | Show address, zero when idle |
| show_trace | output | 1 | Program-trace attribute flag |

## Verification
The assertions assume the fetch source obeys the handshake: a presented fetch keeps fetch_valid high and its fields steady until it is accepted. They also assume vsync does not change again while a trace request is still waiting for FIFO space. The stimulus holds any unaccepted fetch unchanged. It changes vsync only when the reference model shows no trace request outstanding, and it then drains that request before the next change. Downstream readiness is varied randomly, including long stalls, so that the full-FIFO and held-fetch paths are exercised within those limits.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

   localparam int CTRL_W = 3;

   typedef enum logic [1:0] {
      FK_SEQ      = 2'b00,
      FK_DIRECT   = 2'b01,
      FK_INDIRECT = 2'b10,
      FK_RSVD     = 2'b11
   } fetch_kind_e;

   // Filter decision: low two mode bits select the class of fetch shown.
   function automatic logic show_pass(input logic [CTRL_W-1:0] mode,
                                      input logic vs_lvl,
                                      input logic [1:0] kind);
      logic is_ind;
      logic is_dir;
      is_ind = (kind == FK_INDIRECT);
      is_dir = (kind == FK_DIRECT);
      case (mode[1:0])
         2'b00:   return 1'b1;
         2'b01:   return is_dir | is_ind;
         2'b10:   return is_ind;
         default: return vs_lvl & is_ind;
      endcase
   endfunction

endpackage

// File: rtl/fsc_fifo.sv
module fsc_fifo #(
   parameter int W     = 33,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("fsc_fifo: DEPTH must be a power of two of at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("fsc_fifo: W must be positive");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wr_q;
   logic [PW-1:0] rd_q;
   logic [CW-1:0] cnt_q;

   assign empty = (cnt_q == '0);
   assign full  = (cnt_q == CW'(DEPTH));
   assign dout  = mem[rd_q];

   always_ff @(posedge clk) begin
      if (push) begin
         mem[wr_q] <= din;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_q  <= '0;
         rd_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push) begin
            wr_q <= wr_q + 1'b1;
         end
         if (pop) begin
            rd_q <= rd_q + 1'b1;
         end
         cnt_q <= cnt_q + CW'(push) - CW'(pop);
      end
   end

   // R7
   fifo_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> !push);

   // R7
   fifo_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> !pop);

endmodule

// File: rtl/fsc_ctrl_hold.sv
module fsc_ctrl_hold #(
   parameter int CTRL_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fetch_valid,
   input  logic              fetch_ready,
   input  logic [CTRL_W-1:0] ctrl_in,
   input  logic              vs_in,
   output logic [CTRL_W-1:0] ctrl_eff,
   output logic              vs_eff
);
   generate
      if (CTRL_W < 2) begin : g_bad_ctrl
         $error("fsc_ctrl_hold: CTRL_W must be at least 2");
      end
   endgenerate

   logic              held_q;
   logic [CTRL_W-1:0] ctrl_q;
   logic              vs_q;

   // A stalled fetch keeps the settings captured on its first cycle.
   assign ctrl_eff = held_q ? ctrl_q : ctrl_in;
   assign vs_eff   = held_q ? vs_q   : vs_in;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held_q <= 1'b0;
         ctrl_q <= '0;
         vs_q   <= 1'b0;
      end else begin
         held_q <= fetch_valid & ~fetch_ready;
         ctrl_q <= ctrl_eff;
         vs_q   <= vs_eff;
      end
   end

   // R9
   held_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_valid && !fetch_ready) |=> (ctrl_eff == $past(ctrl_eff) && vs_eff == $past(vs_eff)));

endmodule

// File: rtl/fsc_vsync_mark.sv
module fsc_vsync_mark (
   input  logic clk,
   input  logic rst_n,
   input  logic vsync,
   input  logic q_full,
   output logic attr_need,
   output logic attr_push
);
   logic vs_q;
   logic pend_q;
   logic vs_edge;

   assign vs_edge   = vsync ^ vs_q;
   assign attr_need = pend_q | vs_edge;
   assign attr_push = attr_need & ~q_full;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vs_q   <= vsync;
         pend_q <= 1'b0;
      end else begin
         vs_q   <= vsync;
         pend_q <= attr_need & q_full;
      end
   end

   // R5: input rule, vsync stays put while a marked cycle is waiting
   vsync_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q |-> !vs_edge);

   // R5
   attr_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (attr_need && q_full) |=> attr_need);

endmodule

// File: rtl/fsc_show_filter.sv
module fsc_show_filter #(
   parameter int AW             = 32,
   parameter int DEPTH          = 4,
   parameter bit ZERO_IDLE_ADDR = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [2:0]    ctrl_mode,
   input  logic          vsync,
   input  logic          fetch_valid,
   output logic          fetch_ready,
   input  logic [1:0]    fetch_kind,
   input  logic [AW-1:0] fetch_addr,
   output logic          show_valid,
   input  logic          show_ready,
   output logic [AW-1:0] show_addr,
   output logic          show_trace
);
   import fsc_pkg::*;

   localparam int EW = AW + 1;

   generate
      if (AW < 1) begin : g_bad_aw
         $error("fsc_show_filter: AW must be positive");
      end
   endgenerate

   logic              q_full;
   logic              q_empty;
   logic              q_push;
   logic              q_pop;
   logic [EW-1:0]     q_din;
   logic [EW-1:0]     q_dout;
   logic              attr_need;
   logic              attr_push;
   logic              fetch_fire;
   logic              fetch_push;
   logic [CTRL_W-1:0] mode_eff;
   logic              vs_eff;
   logic [AW-1:0]     last_addr_q;

   assign fetch_ready = rst_n & ~q_full & ~attr_need;
   assign fetch_fire  = fetch_valid & fetch_ready;
   assign fetch_push  = fetch_fire & show_pass(mode_eff, vs_eff, fetch_kind);

   assign q_push = attr_push | fetch_push;
   assign q_din  = attr_push ? {1'b1, last_addr_q} : {1'b0, fetch_addr};
   assign q_pop  = show_valid & show_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         last_addr_q <= '0;
      end else if (fetch_fire) begin
         last_addr_q <= fetch_addr;
      end
   end

   fsc_ctrl_hold #(.CTRL_W(CTRL_W)) hold_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .fetch_valid (fetch_valid),
      .fetch_ready (fetch_ready),
      .ctrl_in     (ctrl_mode),
      .vs_in       (vsync),
      .ctrl_eff    (mode_eff),
      .vs_eff      (vs_eff)
   );

   fsc_vsync_mark mark_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .vsync     (vsync),
      .q_full    (q_full),
      .attr_need (attr_need),
      .attr_push (attr_push)
   );

   fsc_fifo #(.W(EW), .DEPTH(DEPTH)) fifo_i (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (q_push),
      .din   (q_din),
      .pop   (q_pop),
      .dout  (q_dout),
      .empty (q_empty),
      .full  (q_full)
   );

   assign show_valid = ~q_empty;
   assign show_trace = ~q_empty & q_dout[AW];

   generate
      if (ZERO_IDLE_ADDR) begin : g_zero_idle
         assign show_addr = q_empty ? '0 : q_dout[AW-1:0];

         // R6
         idle_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !show_valid |-> (show_addr == '0));
      end else begin : g_raw_addr
         assign show_addr = q_dout[AW-1:0];
      end
   endgenerate

   // R8
   attr_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vsync != $past(vsync)) |-> !fetch_ready);

   // R4
   quiet_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_push |-> !(mode_eff[1:0] == 2'b11 && !vs_eff));

   // R5
   attr_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
      attr_push |=> show_valid);

   // R10
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |-> !fetch_ready);

endmodule

// File: tb/fsc_show_filter_tb_top.sv
module fsc_show_filter_tb_top;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int AW    = 32;
   localparam int DEPTH = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [2:0]    ctrl_mode = 3'b000;
   logic          vsync = 1'b0;
   logic          fetch_valid = 1'b0;
   logic          fetch_ready;
   logic [1:0]    fetch_kind = 2'b00;
   logic [AW-1:0] fetch_addr = '0;
   logic          show_valid;
   logic          show_ready = 1'b0;
   logic [AW-1:0] show_addr;
   logic          show_trace;

   always #4 clk = ~clk;

   fsc_show_filter #(.AW(AW), .DEPTH(DEPTH)) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .ctrl_mode   (ctrl_mode),
      .vsync       (vsync),
      .fetch_valid (fetch_valid),
      .fetch_ready (fetch_ready),
      .fetch_kind  (fetch_kind),
      .fetch_addr  (fetch_addr),
      .show_valid  (show_valid),
      .show_ready  (show_ready),
      .show_addr   (show_addr),
      .show_trace  (show_trace)
   );

   typedef struct {
      bit            tr;
      logic [AW-1:0] a;
   } ent_t;

   ent_t          ref_q[$];
   bit            m_pend, m_vprev, m_held, m_vs, m_fire;
   logic [2:0]    m_mode;
   logic [AW-1:0] m_last;

   int    n_tests = 0;
   int    n_fail  = 0;
   string cur_req = "R1";
   bit    checking = 1'b0;
   int    toggles = 0;
   int    dut_traces = 0;
   int    seen_target = 0;
   logic [AW-1:0] target_addr = 32'hFFFF_FFF0;

   // Which fetch kinds each mode shows, written from the requirement list.
   function automatic bit ref_pass(input logic [2:0] md, input bit vl, input logic [1:0] k);
      if (md[1:0] == 2'b00) return 1'b1;
      if (md[1:0] == 2'b01) return (k == 2'b01) || (k == 2'b10);
      if (md[1:0] == 2'b10) return (k == 2'b10);
      return vl && (k == 2'b10);
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input longint unsigned act, input longint unsigned exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Behavioural reference, advanced on each rising edge.
   always @(posedge clk) begin
      bit full, edg, need, rdy, ev;
      logic [2:0] em;
      if (!rst_n) begin
         ref_q.delete();
         m_pend = 1'b0; m_vprev = vsync; m_held = 1'b0; m_vs = 1'b0;
         m_mode = 3'b000; m_last = '0; m_fire = 1'b0;
      end else begin
         full = (ref_q.size() == DEPTH);
         edg  = (vsync != m_vprev);
         need = m_pend || edg;
         rdy  = !full && !need;
         em   = m_held ? m_mode : ctrl_mode;
         ev   = m_held ? m_vs : vsync;
         m_fire = fetch_valid && rdy;
         if (ref_q.size() > 0 && show_ready) void'(ref_q.pop_front());
         if (need && !full) ref_q.push_back('{tr: 1'b1, a: m_last});
         else if (m_fire && ref_pass(em, ev, fetch_kind)) ref_q.push_back('{tr: 1'b0, a: fetch_addr});
         m_pend  = need && full;
         m_vprev = vsync;
         m_held  = fetch_valid && !rdy;
         m_mode  = em;
         m_vs    = ev;
         if (m_fire) m_last = fetch_addr;
      end
   end

   // Compare every clock, late in the cycle after inputs settle.
   always @(posedge clk) begin
      if (checking) begin
         bit ev_valid, ev_tr, ev_rdy;
         logic [AW-1:0] ev_addr;
         #6;
         ev_valid = (ref_q.size() > 0);
         ev_addr  = ev_valid ? ref_q[0].a : '0;
         ev_tr    = ev_valid ? ref_q[0].tr : 1'b0;
         ev_rdy   = (ref_q.size() != DEPTH) && !(m_pend || (vsync != m_vprev));
         chk(fetch_ready == ev_rdy, cur_req, "fetch_ready", fetch_ready, ev_rdy);
         chk(show_valid == ev_valid, cur_req, "show_valid", show_valid, ev_valid);
         chk(show_addr == ev_addr, cur_req, "show_addr", show_addr, ev_addr);
         chk(show_trace == ev_tr, cur_req, "show_trace", show_trace, ev_tr);
         if (!show_valid) chk(show_addr == '0, "R6", "idle show_addr", show_addr, 0);
         if (show_valid && show_ready && show_trace) dut_traces++;
         if (show_valid && show_ready && !show_trace && show_addr == target_addr) seen_target++;
      end
   end

   task automatic step(input bit allow_new, input int rdy_pct, input bit flip);
      @(negedge clk);
      if (!(fetch_valid && !m_fire)) begin
         fetch_valid = allow_new && ($urandom_range(99) < 60);
         fetch_kind  = 2'($urandom_range(3));
         fetch_addr  = AW'($urandom()) & ~AW'(15);
         if (fetch_addr == target_addr) fetch_addr = '0;
      end
      show_ready = ($urandom_range(99) < rdy_pct);
      if (flip) begin
         vsync = ~vsync;
         toggles++;
      end
   endtask

   task automatic toggle_vs();
      while (m_pend) step(1'b1, 100, 1'b0);
      step(1'b1, 60, 1'b1);
      #2;
      // R8: the marked cycle wins the slot, so no fetch is taken now
      chk(fetch_ready == 1'b0, "R8", "fetch_ready on vsync change", fetch_ready, 0);
      step(1'b1, 100, 1'b0);
      while (m_pend) step(1'b1, 100, 1'b0);
   endtask

   task automatic set_vs(input bit v);
      if (vsync != v) toggle_vs();
   endtask

   task automatic drain();
      int guard = 0;
      while ((ref_q.size() > 0 || (fetch_valid && !m_fire) || m_pend) && guard < 200) begin
         step(1'b0, 100, 1'b0);
         guard++;
      end
      @(negedge clk);
      fetch_valid = 1'b0;
   endtask

   task automatic run_phase(input logic [2:0] md, input bit v, input int n,
                            input int rdy_pct, input string req);
      cur_req = req;
      set_vs(v);
      ctrl_mode = md;
      repeat (n) step(1'b1, rdy_pct, 1'b0);
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      #(200000 * 8);
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_run();
   end

   initial begin
      // R10: reset state
      repeat (3) @(negedge clk);
      chk(fetch_ready == 1'b0, "R10", "fetch_ready in reset", fetch_ready, 0);
      chk(show_valid == 1'b0, "R10", "show_valid in reset", show_valid, 0);
      rst_n = 1'b1;
      checking = 1'b1;
      #1;
      chk(fetch_ready == 1'b1, "R10", "fetch_ready after reset", fetch_ready, 1);
      chk(show_valid == 1'b0, "R10", "show_valid after reset", show_valid, 0);

      run_phase(3'b000, 1'b0, 300, 70, "R1");
      run_phase(3'b100, 1'b1, 200, 70, "R1");
      run_phase(3'b001, 1'b1, 300, 70, "R2");
      run_phase(3'b101, 1'b0, 200, 50, "R2");
      run_phase(3'b010, 1'b0, 300, 70, "R3");
      run_phase(3'b110, 1'b1, 200, 70, "R3");
      run_phase(3'b011, 1'b0, 300, 70, "R4");
      run_phase(3'b111, 1'b1, 300, 70, "R4");
      run_phase(3'b011, 1'b1, 200, 40, "R4");
      run_phase(3'b000, 1'b0, 400, 15, "R7");
      cur_req = "R8";
      ctrl_mode = 3'b001;
      for (int i = 0; i < 10; i++) begin
         toggle_vs();
         repeat (5) step(1'b1, 30, 1'b0);
      end
      drain();

      // R9: fill the queue, hold an indirect fetch, switch to a silent mode
      cur_req = "R9";
      set_vs(1'b0);
      drain();
      ctrl_mode = 3'b000;
      for (int i = 0; i < DEPTH; i++) begin
         @(negedge clk);
         fetch_valid = 1'b1; fetch_kind = 2'b00; fetch_addr = AW'(i * 16); show_ready = 1'b0;
      end
      @(negedge clk);
      fetch_valid = 1'b1; fetch_kind = 2'b10; fetch_addr = target_addr;
      ctrl_mode = 3'b010; show_ready = 1'b0;
      #2;
      // R7: queue holds DEPTH entries
      chk(fetch_ready == 1'b0, "R7", "fetch_ready when full", fetch_ready, 0);
      @(negedge clk);
      ctrl_mode = 3'b011;
      repeat (3) @(negedge clk);
      show_ready = 1'b1;
      while (!(fetch_valid && m_fire)) @(negedge clk);
      fetch_valid = 1'b0;
      drain();
      chk(seen_target == 1, "R9", "held fetch shown once", seen_target, 1);

      // R5: one marked request per vsync change
      chk(dut_traces == toggles, "R5", "trace-flagged requests", dut_traces, toggles);
      repeat (2) @(negedge clk);
      checking = 1'b0;
      finish_run();
   end

endmodule